// File: doc/BRIEF.md
# External Bus Write-Cycle Sequencer

This block produces write accesses on an asynchronous external memory bus. Each accepted request becomes an access with three phases. A lead phase asserts chip-select and the read/not-write line. An active phase also asserts the write strobe. A trail phase follows, then the bus returns to idle. The length of each phase is set in cycles of the internal timing clock, and a programmed length of zero is treated as one cycle. Write data is driven with its output enable high for the whole access.

The block also drives a bus clock. This clock is either the timing clock itself or the timing clock divided by two. Every access must begin on a rising edge of the bus clock. When the divided clock is selected and a request would start in the wrong half-period, one alignment cycle is inserted first, with all strobes inactive. The address output changes only when a lead phase begins, and it keeps the previous value through idle and alignment cycles.

When ready mode is enabled, an external ready pin can stretch the active phase one cycle at a time. The pin passes through a two-flop synchronizer. The first effective sample is taken at the clock edge (lead + active − 2) cycles after lead begins, and each later sample is one cycle after the one before.

Top module: `ext_write_seq`

## Requirements
- R1: With effective lengths L, A and T (a programmed 0 counts as 1), lead lasts L cycles, active lasts at least A cycles and trail lasts T cycles. In the setting lead=1, active=3, trail=1 with ready high, chip-select is low for exactly 5 cycles and the write strobe is low for 3 of them.
- R2: `cs_n` and `rnw` are low (active) from the first lead cycle through the last trail cycle. Both are high in every other cycle, including alignment cycles.
- R3: `we_n` is low exactly during the active phase, including any cycles added by ready, and never while `cs_n` is high.
- R4: `dout_oe` is high from the first lead cycle through the last trail cycle and low otherwise. While it is high, `dout` equals the data of the accepted request.
- R5: `addr` takes the accepted request's address in the first lead cycle. It holds its value in every idle and alignment cycle.
- R6: When `cfg_half_rate`=1, `bus_clk` toggles every timing-clock cycle and is high in every first lead cycle. If needed, exactly one alignment cycle comes between acceptance and lead. When `cfg_half_rate`=0, `bus_clk` follows `clk`.
- R7: With `cfg_rdy_en`=1, the pin level captured at the edge (L + A − 2) cycles after lead begins decides whether the A-th active cycle is the last one. If that level is low, active is extended by one cycle, and the next edge's capture decides again.
- R8: With `cfg_rdy_en`=0, `rdy_pin` has no effect: active lasts exactly A cycles even while the pin is held low.
- R9: `ack` is high in exactly those cycles where the block is idle and `req` is high, and the request is accepted in that cycle. A request present during a busy or alignment cycle is ignored.
- R10: `done` is high for exactly one cycle, the last trail cycle of each access.
- R11: While `rst_n` is low, `cs_n`, `we_n` and `rnw` are high, `dout_oe` and `done` are low, and `addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lead | input | CW | Lead phase length in cycles (0 means 1) |
| cfg_active | input | CW | Minimum active phase length (0 means 1) |
| cfg_trail | input | CW | Trail phase length (0 means 1) |
| cfg_rdy_en | input | 1 | Enables stretching of the active phase by ready |
| cfg_half_rate | input | 1 | 1 selects a bus clock at half the timing-clock rate |
| req | input | 1 | Write request |
| req_addr | input | AW | Address of the request |
| req_data | input | DW | Data of the request |
| ack | output | 1 | Request accepted this cycle |
| done | output | 1 | Last trail cycle of an access |
| rdy_pin | input | 1 | Asynchronous external ready |
| bus_clk | output | 1 | Bus output clock |
| cs_n | output | 1 | Zone chip-select, active low |
| we_n | output | 1 | Write strobe, active low |
| rnw | output | 1 | Read/not-write, low during writes |
| addr | output | AW | Bus address |
| dout | output | DW | Write data |
| dout_oe | output | 1 | Output enable for write data |

## Verification
Two events can fall in the same cycle. The decision to end an access (the last trail cycle with `done`) can coincide with a request that was held high through the access. The ready sample can land on the final programmed active cycle while the same access also needed an alignment cycle. The bench holds `req` high with a new address on every cycle, so acceptance must happen in the first idle cycle after `done`. That acceptance must also decide whether the next access needs alignment at that moment. The ready pin and requests are driven from a pseudo-random pattern in both clock modes. A behavioural model keeps its own cycle index within each access and its own history of the pin. Every output is compared with the model on each clock.

// File: rtl/ext_write_seq.sv
module ext_write_seq #(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_trail,
  input  logic          cfg_rdy_en,
  input  logic          cfg_half_rate,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic          done,
  input  logic          rdy_pin,
  output logic          bus_clk,
  output logic          cs_n,
  output logic          we_n,
  output logic          rnw,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);

  typedef enum logic [2:0] {S_IDLE, S_ALIGN, S_LEAD, S_ACT, S_TRAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          ph;
  logic          rdy_m, rdy_s;
  logic [AW-1:0] addr_pend;
  logic [DW-1:0] data_q;
  logic [CW-1:0] lead_m1, act_m1, trail_m1;
  logic          busy, go_trail;

  assign lead_m1  = (cfg_lead   == '0) ? '0 : CW'(cfg_lead   - 1'b1);
  assign act_m1   = (cfg_active == '0) ? '0 : CW'(cfg_active - 1'b1);
  assign trail_m1 = (cfg_trail  == '0) ? '0 : CW'(cfg_trail  - 1'b1);

  assign busy     = (st == S_LEAD) || (st == S_ACT) || (st == S_TRAIL);
  assign go_trail = !cfg_rdy_en || rdy_s;

  assign cs_n    = ~busy;
  assign rnw     = ~busy;
  assign we_n    = (st != S_ACT);
  assign dout_oe = busy;
  assign dout    = data_q;
  assign ack     = (st == S_IDLE) && req;
  assign done    = (st == S_TRAIL) && (cnt == '0);
  assign bus_clk = cfg_half_rate ? ph : clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      rdy_m <= 1'b0;
      rdy_s <= 1'b0;
    end else begin
      ph    <= ~ph;
      rdy_m <= rdy_pin;
      rdy_s <= rdy_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr      <= '0;
      addr_pend <= '0;
      data_q    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req) begin
          addr_pend <= req_addr;
          data_q    <= req_data;
          if (cfg_half_rate && ph) begin
            st <= S_ALIGN;
          end else begin
            st   <= S_LEAD;
            addr <= req_addr;
            cnt  <= lead_m1;
          end
        end
        S_ALIGN: begin
          st   <= S_LEAD;
          addr <= addr_pend;
          cnt  <= lead_m1;
        end
        S_LEAD: if (cnt == '0) begin
          st  <= S_ACT;
          cnt <= act_m1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_ACT: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (go_trail) begin
          st  <= S_TRAIL;
          cnt <= trail_m1;
        end
        S_TRAIL: if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ext_write_seq_chk.sv
module ext_write_seq_chk #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_half_rate,
  input logic          ack,
  input logic          done,
  input logic          bus_clk,
  input logic          cs_n,
  input logic          we_n,
  input logic          rnw,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);

  assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);

  assert_rnw_tracks_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rnw == cs_n);

  assert_lead_before_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> we_n);

  assert_trail_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !cs_n);

  assert_addr_held_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> $stable(addr));

  assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(dout));

  assert_oe_matches_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe == !cs_n);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cs_n);

  assert_ack_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> cs_n);

  assert_lead_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_half_rate && $fell(cs_n)) |-> bus_clk);

endmodule

bind ext_write_seq ext_write_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_half_rate(cfg_half_rate), .ack(ack), .done(done),
  .bus_clk(bus_clk), .cs_n(cs_n), .we_n(we_n), .rnw(rnw), .addr(addr),
  .dout(dout), .dout_oe(dout_oe)
);

// File: tb/tb_ext_write_seq.sv
`timescale 1ns/1ps
module tb_ext_write_seq;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_lead = 4'd1, cfg_active = 4'd3, cfg_trail = 4'd1;
  logic cfg_rdy_en = 1'b1, cfg_half_rate = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic rdy_pin = 1'b1;
  logic ack, done, bus_clk, cs_n, we_n, rnw, dout_oe;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout;

  always #2.5 clk = ~clk;

  ext_write_seq #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
    .cfg_trail(cfg_trail), .cfg_rdy_en(cfg_rdy_en), .cfg_half_rate(cfg_half_rate),
    .req(req), .req_addr(req_addr), .req_data(req_data), .ack(ack), .done(done),
    .rdy_pin(rdy_pin), .bus_clk(bus_clk), .cs_n(cs_n), .we_n(we_n), .rnw(rnw),
    .addr(addr), .dout(dout), .dout_oe(dout_oe)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  int cyc, mst, pos, ext;
  bit h0, h1, h2;
  logic [AW-1:0] p_addr, m_addr;
  logic [DW-1:0] p_data;

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; mst = 0; pos = 0; ext = 0;
      h0 = 0; h1 = 0; h2 = 0;
      p_addr = '0; m_addr = '0; p_data = '0;
    end else begin
      cyc++;
      h2 = h1; h1 = h0; h0 = rdy_pin;
      if (mst == 0) begin
        if (req) begin
          p_addr = req_addr; p_data = req_data;
          if (cfg_half_rate && (cyc % 2 == 0)) mst = 1;
          else begin mst = 2; pos = 0; ext = 0; m_addr = p_addr; end
        end
      end else if (mst == 1) begin
        mst = 2; pos = 0; ext = 0; m_addr = p_addr;
      end else begin
        if (cfg_rdy_en && pos == eff(cfg_lead) + eff(cfg_active) + ext - 1 && !h2) ext++;
        pos++;
        if (pos == eff(cfg_lead) + eff(cfg_active) + ext + eff(cfg_trail)) mst = 0;
      end
    end
  end

  int cs_run = 0, we_run = 0, last_cs = 0, last_we = 0, misaligned = 0;
  bit prev_cs = 1'b1;

  always @(negedge clk) begin
    bit bad, e_busy, e_act, e_done, e_ack, e_bclk;
    int la;
    #1;
    la = eff(cfg_lead) + eff(cfg_active) + ext;
    e_busy = (mst == 2);
    e_act  = e_busy && pos >= eff(cfg_lead) && pos < la;
    e_done = e_busy && pos == la + eff(cfg_trail) - 1;
    e_ack  = (mst == 0) && req;
    e_bclk = cfg_half_rate ? bit'(cyc % 2) : clk;
    bad = 0;
    vectors++;
    if (cs_n !== !e_busy) begin bad = 1; $display("FAIL R2 cs_n got %b exp %b at %0t", cs_n, !e_busy, $time); end
    if (rnw !== !e_busy) begin bad = 1; $display("FAIL R2 rnw got %b exp %b at %0t", rnw, !e_busy, $time); end
    if (we_n !== !e_act) begin bad = 1; $display("FAIL R3 we_n got %b exp %b at %0t", we_n, !e_act, $time); end
    if (dout_oe !== e_busy) begin bad = 1; $display("FAIL R4 dout_oe got %b exp %b at %0t", dout_oe, e_busy, $time); end
    if (e_busy && dout !== p_data) begin bad = 1; $display("FAIL R4 dout got %h exp %h at %0t", dout, p_data, $time); end
    if (addr !== m_addr) begin bad = 1; $display("FAIL R5 addr got %h exp %h at %0t", addr, m_addr, $time); end
    if (bus_clk !== e_bclk) begin bad = 1; $display("FAIL R6 bus_clk got %b exp %b at %0t", bus_clk, e_bclk, $time); end
    if (ack !== e_ack) begin bad = 1; $display("FAIL R9 ack got %b exp %b at %0t", ack, e_ack, $time); end
    if (done !== e_done) begin bad = 1; $display("FAIL R10 done got %b exp %b at %0t", done, e_done, $time); end
    if (bad) miscompares++;
    if (!cs_n && prev_cs && cfg_half_rate && !bus_clk) misaligned++;
    if (!cs_n) cs_run++; else if (cs_run > 0) begin last_cs = cs_run; cs_run = 0; end
    if (!we_n) we_run++; else if (we_run > 0) begin last_we = we_run; we_run = 0; end
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; req_addr = a; req_data = d;
    #1;
    while (!ack) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_access();
    #1;
    while (!done) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog expired");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(cs_n === 1'b1 && we_n === 1'b1 && rnw === 1'b1, "R11 strobes in reset", int'({cs_n, we_n, rnw}), 7);
    chk(dout_oe === 1'b0 && done === 1'b0, "R11 oe/done in reset", int'({dout_oe, done}), 0);
    chk(addr === '0, "R11 addr in reset", int'(addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reference setting: 1/3/1, ready enabled and high, full rate
    issue(19'h12345, 16'hBEEF);
    finish_access();
    chk(last_cs == 5, "R1 chip-select length", last_cs, 5);
    chk(last_we == 3, "R1 strobe length", last_we, 3);

    // R7 ready held low, released five cycles into the access
    rdy_pin = 1'b0;
    issue(19'h00ABC, 16'h1234);
    repeat (5) @(negedge clk);
    rdy_pin = 1'b1;
    finish_access();
    chk(last_we == 7, "R7 stretched active length", last_we, 7);
    chk(last_cs == 9, "R7 stretched access length", last_cs, 9);

    // R8 ready disabled, zero counts treated as one
    cfg_rdy_en = 1'b0; cfg_lead = 0; cfg_active = 0; cfg_trail = 0;
    rdy_pin = 1'b0;
    issue(19'h7FFFF, 16'h5A5A);
    finish_access();
    chk(last_we == 1, "R8 ready ignored, active length", last_we, 1);
    chk(last_cs == 3, "R1 zero counts, access length", last_cs, 3);

    // R6 half rate with varying gaps hits both alignments
    cfg_half_rate = 1'b1; cfg_rdy_en = 1'b1; rdy_pin = 1'b1;
    cfg_lead = 2; cfg_active = 2; cfg_trail = 1;
    for (int g = 0; g < 4; g++) begin
      repeat (g) @(negedge clk);
      issue(19'(g * 19'h1111), 16'(16'hA000 + g));
      finish_access();
    end
    chk(misaligned == 0, "R6 lead on bus-clock rise", misaligned, 0);

    // R9 request held high through accesses, address changing each cycle
    cfg_half_rate = 1'b0;
    @(negedge clk);
    req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      req_addr = 19'(i * 7 + 3); req_data = 16'(i * 13);
      @(negedge clk);
    end
    req = 1'b0;
    repeat (20) @(negedge clk);

    // R7 random ready and requests in both clock modes
    lfsr = 16'hACE1;
    for (int m = 0; m < 2; m++) begin
      cfg_half_rate = m[0]; cfg_lead = 4'(1 + m); cfg_active = 2; cfg_trail = 3;
      for (int i = 0; i < 300; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rdy_pin = lfsr[0] | lfsr[3];
        req = lfsr[5];
        req_addr = 19'(lfsr) ^ 19'(i);
        req_data = lfsr ^ 16'(i);
        @(negedge clk);
      end
      req = 1'b0; rdy_pin = 1'b1;
      repeat (40) @(negedge clk);
    end
    chk(misaligned == 0, "R6 lead on bus-clock rise, random", misaligned, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule